// File: doc/BRIEF.md
# Two-Channel DC Offset Calibration Engine

This block removes a DC offset from two 10-bit sample streams, called I and Q, that arrive one sample per clock. The stored offset of each channel starts at zero, so after reset each sample passes through unchanged apart from one register stage. A calibration is started by a rising edge on a request input. A fixed window then follows. Its first cycles are thrown away while the inputs settle. Every later sample in the window is measured against mid-scale (512), and the deviations are summed. The sum is divided by the sample count and stored as a signed offset for that channel alone.

After the window closes, each incoming sample has its own channel's offset subtracted. The result is clamped to the 10-bit range rather than wrapping. A busy output covers the whole window. Samples keep flowing during calibration and are corrected with the previous offset until the new one is loaded. Holding the request high does not start another window, and a new edge during an active window is ignored.

Top module: `offset_cal_engine`

## Requirements
- R1: After reset, iCorr, qCorr and busy are 0 and both stored offsets are 0, so each output equals its input sample delayed by one clock.
- R2: A calibration starts only when calReq is sampled high after being sampled low on the previous clock; calReq is treated as low before the first clock after reset. Holding calReq high starts nothing further.
- R3: busy rises on the clock edge that samples the calReq rising edge and stays high for exactly 34 cycles.
- R4: A calReq rising edge sampled while busy is high is ignored: it neither extends nor restarts the window.
- R5: The samples taken on the first 2 busy cycles are discarded. The samples on the remaining 32 busy cycles, including the last one, are accumulated.
- R6: The new offset equals floor(sum of (sample − 512) over the 32 accumulated samples / 32), a signed value. It is loaded on the edge where busy falls.
- R7: Each output equals clamp(sample − offset), registered and valid one clock after the sample is presented.
- R8: A corrected value below 0 is output as 0, and a value above 1023 is output as 1023.
- R9: The I and Q channels compute and store their offsets independently, from their own samples.
- R10: While busy is high, outputs are corrected with the offset that was stored before the window began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per channel per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| calReq | input | 1 | Calibration request; a rising edge starts a window |
| iSample | input | 10 | I channel raw sample, unsigned |
| qSample | input | 10 | Q channel raw sample, unsigned |
| iCorr | output | 10 | I channel corrected sample |
| qCorr | output | 10 | Q channel corrected sample |
| busy | output | 1 | High during the 34-cycle calibration window |

## Verification
The bench places extreme samples in the two settling cycles, so a design that accumulates them, or that accumulates one cycle too early or too late, stores a visibly wrong offset. It holds calReq high after a window ends and drops and raises it again in the middle of a window. An implementation that treats the level as a trigger, or that lets a mid-window edge restart the window, ends busy at the wrong time. Mixed-sign sums with a fractional average test floor rounding: a truncating divider lands one code off on the negative channel. Samples near both ends of the scale test the clamp against wraparound. Checks on outputs during the second window confirm that the old offset is still applied.

// File: rtl/offcal_pkg.sv
package offcal_pkg;
  // Strobes from the sequencer to each channel datapath
  typedef struct packed {
    logic clearAcc;  // start of window: zero the accumulator
    logic accEn;     // add this cycle's deviation
    logic loadOff;   // last window cycle: commit the averaged offset
  } calStrobes_t;
endpackage

// File: rtl/offcal_ctrl.sv
module offcal_ctrl
  import offcal_pkg::*;
#(
  parameter int SETTLE   = 2,
  parameter int AVG_LOG2 = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        calReq,
  output logic        busy,
  output calStrobes_t strb
);
  localparam int SEQ_LEN = SETTLE + (1 << AVG_LOG2);
  localparam int CNT_W   = $clog2(SEQ_LEN);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SEQ_LEN - 1);
  localparam logic [CNT_W-1:0] FIRST_ACC = CNT_W'(SETTLE);

  logic             calReqQ;
  logic             active;
  logic [CNT_W-1:0] seqCnt;
  logic             reqRise;

  assign reqRise = calReq & ~calReqQ;
  assign busy    = active;

  always_comb begin
    strb.clearAcc = reqRise & ~active;
    strb.accEn    = active && (seqCnt >= FIRST_ACC);
    strb.loadOff  = active && (seqCnt == LAST_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calReqQ <= 1'b0;
      active  <= 1'b0;
      seqCnt  <= '0;
    end else begin
      calReqQ <= calReq;
      if (active) begin
        if (seqCnt == LAST_CNT) begin
          active <= 1'b0;
          seqCnt <= '0;
        end else begin
          seqCnt <= seqCnt + 1'b1;
        end
      end else if (reqRise) begin
        active <= 1'b1;
        seqCnt <= '0;
      end
    end
  end

  // Independent run-length counter for the window length check
  logic [CNT_W:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  p_start_on_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(calReq));

  p_window_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == (CNT_W+1)'(SEQ_LEN)));

  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.loadOff) |=> busy);

  p_load_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOff |=> !busy);
endmodule

// File: rtl/offcal_datapath.sv
module offcal_datapath
  import offcal_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int AVG_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  calStrobes_t         strb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] corrOut
);
  localparam int OFF_W  = SAMPLE_W + 1;
  localparam int ACC_W  = SAMPLE_W + AVG_LOG2 + 1;
  localparam int DIFF_W = SAMPLE_W + 2;
  localparam logic signed [OFF_W-1:0]  MID  = OFF_W'(1 << (SAMPLE_W - 1));
  localparam logic signed [DIFF_W-1:0] MAXV = DIFF_W'((1 << SAMPLE_W) - 1);

  logic signed [OFF_W-1:0]  dev;
  logic signed [OFF_W-1:0]  offReg;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accNext;
  logic signed [DIFF_W-1:0] rawDiff;
  logic [SAMPLE_W-1:0]      clampVal;

  always_comb begin
    dev     = $signed({1'b0, sampleIn}) - MID;
    accNext = acc + ACC_W'(dev);
    rawDiff = $signed({2'b00, sampleIn}) - DIFF_W'(offReg);
    if (rawDiff < 0)         clampVal = '0;
    else if (rawDiff > MAXV) clampVal = '1;
    else                     clampVal = rawDiff[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      offReg  <= '0;
      corrOut <= '0;
    end else begin
      corrOut <= clampVal;
      if (strb.clearAcc)   acc <= '0;
      else if (strb.accEn) acc <= accNext;
      if (strb.loadOff)    offReg <= OFF_W'(accNext >>> AVG_LOG2);
    end
  end

  p_hold_offset_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadOff |=> $stable(offReg));

  p_clamp_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rawDiff < 0) |=> (corrOut == '0));

  p_clamp_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rawDiff > MAXV) |=> (corrOut == '1));
endmodule

// File: rtl/offset_cal_engine.sv
module offset_cal_engine
  import offcal_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int SETTLE   = 2,
  parameter int AVG_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                calReq,
  input  logic [SAMPLE_W-1:0] iSample,
  input  logic [SAMPLE_W-1:0] qSample,
  output logic [SAMPLE_W-1:0] iCorr,
  output logic [SAMPLE_W-1:0] qCorr,
  output logic                busy
);
  localparam int NUM_CH = 2;

  calStrobes_t         strb;
  logic [SAMPLE_W-1:0] chIn  [NUM_CH];
  logic [SAMPLE_W-1:0] chOut [NUM_CH];

  assign chIn[0] = iSample;
  assign chIn[1] = qSample;
  assign iCorr   = chOut[0];
  assign qCorr   = chOut[1];

  offcal_ctrl #(.SETTLE(SETTLE), .AVG_LOG2(AVG_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .calReq(calReq), .busy(busy), .strb(strb)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    offcal_datapath #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) u_dp (
      .clk(clk), .rstN(rstN), .strb(strb),
      .sampleIn(chIn[c]), .corrOut(chOut[c])
    );
  end
endmodule

// File: tb/offset_cal_engine_bench.sv
`timescale 1ns/1ps
module offset_cal_engine_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       calReq = 1'b0;
  logic [9:0] iS = '0;
  logic [9:0] qS = '0;
  logic [9:0] iCorr, qCorr;
  logic       busy;

  offset_cal_engine u_offset_cal_engine (
    .clk(clk), .rstN(rstN), .calReq(calReq), .iSample(iS), .qSample(qS),
    .iCorr(iCorr), .qCorr(qCorr), .busy(busy)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int    expI[$];
  int    expQ[$];
  bit    expB[$];
  string expT[$];

  // Reference model state, built from the requirements
  int mOffI = 0, mOffQ = 0, mAccI = 0, mAccQ = 0, mCnt = 0;
  bit mAct = 0, mPrev = 0;

  function automatic int clampv(int v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: presents one sample pair and pushes the expected outputs
  task automatic step(int i, int q, bit req, string tag);
    bit rise;
    @(negedge clk);
    iS = i[9:0];
    qS = q[9:0];
    calReq = req;
    expI.push_back(clampv(i - mOffI));   // R7 R8 R10
    expQ.push_back(clampv(q - mOffQ));   // R9
    rise = req && !mPrev;
    if (mAct) begin
      if (mCnt >= 2) begin               // R5
        mAccI += i - 512;
        mAccQ += q - 512;
      end
      if (mCnt == 33) begin              // R6
        mOffI = mAccI >>> 5;
        mOffQ = mAccQ >>> 5;
        mAct = 0;
      end else mCnt++;
    end else if (rise) begin             // R2
      mAct = 1; mCnt = 0; mAccI = 0; mAccQ = 0;
    end
    mPrev = req;
    expB.push_back(mAct);                // R3 R4
    expT.push_back(tag);
  endtask

  // Monitor: pops expected items after each edge
  always begin
    @(posedge clk);
    #2;
    if (expI.size() > 0) begin
      string t;
      t = expT.pop_front();
      check({t, " I"}, int'(iCorr), expI.pop_front());
      check({t, " Q"}, int'(qCorr), expQ.pop_front());
      check({"R3 busy at ", t}, int'(busy), int'(expB.pop_front()));
    end
  end

  initial begin
    #150000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #45;
    check("R1 reset I", int'(iCorr), 0);
    check("R1 reset Q", int'(qCorr), 0);
    check("R1 reset busy", int'(busy), 0);
    @(negedge clk);
    rstN = 1'b1;

    // Zero offset: pass-through
    step(100, 900, 0, "R1");
    step(0, 1023, 0, "R7");
    step(513, 511, 0, "R7");

    // First calibration: edge cycle, two garbage settling samples, 32 real
    step(700, 300, 1, "R2");
    step(1023, 0, 1, "R5");
    step(1023, 0, 1, "R5");
    for (int k = 0; k < 32; k++) step(532, 505, 1, "R5");

    // Level held high: no restart; new offsets I=20, Q=-7
    for (int k = 0; k < 4; k++) step(532, 505, 1, "R2");
    step(600, 600, 1, "R9");
    step(10, 1020, 1, "R8");
    step(1023, 0, 1, "R8");
    step(20, 1016, 0, "R8");

    // Second calibration with fractional averages and a mid-window edge
    step(512, 511, 1, "R2");
    for (int k = 0; k < 34; k++) begin
      bit r;
      r = !(k == 10 || k == 11);
      step(512 + (k % 2), 511 + (k % 2), r, (k >= 10 && k <= 13) ? "R4" : "R10");
    end
    // Expected offsets now I=0, Q=-1
    step(600, 600, 0, "R6");
    step(0, 1023, 0, "R6");
    step(300, 700, 1, "R9");
    step(300, 700, 1, "R9");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule